// File: doc/BRIEF.md
# Converter Control Register Bank with Read Redirection

This block is the register side of a data converter's digital interface. A host writes a register with two word strobes: first an address word, then a 16-bit data word. The block holds a control register, a digital gain register and an overrange threshold register. It also assembles a read-only status word from live converter state. The persistent control bits drive the power-down, low-power, reference-buffer, reference-bypass and amplifier-enable outputs.

Each read strobe normally returns the current conversion sample. Three one-shot selector bits in the control word redirect only the next read to the threshold register, the gain register or the status word. After that one read, reads return conversion samples again. A further one-shot bit fires a single-cycle synchronization pulse, which also clears the filter-settled flag. None of the one-shot bits is retained in the control register. A control write that sets more than one selector is rejected and flagged.

Top module: `cnv_regbank`

## Requirements
- R1: After reset the control register is 0x0000. So pwr_down, low_power and ref_bypass are 0, ref_buf_en and amp_en are 1, and sync_pulse, cfg_err and rd_word are 0. gain_o equals the parameter GAIN_RST (default 0x4000), the threshold equals THR_RST (default 0x7FFF), no redirect is armed and the filter-settled flag is 0.
- R2: A register write is an address word on wr_addr_stb followed by a data word on wr_data_stb. A data strobe only takes effect when an address word is pending, and it consumes that address. A data strobe with no pending address is ignored.
- R3: Addresses are: control 0x0001, gain 0x0002, threshold 0x0003, status 0x0004. The control bits work as follows.
  - Bit 3 gives pwr_down, which forces ref_buf_en and amp_en low while the other registers keep their contents. Writing 0 to bit 3 restores normal operation.
  - Bit 1 clears ref_buf_en.
  - Bit 0 clears amp_en.
  - Bit 2 gives low_power.
  - Bit 7 gives ref_bypass, but only while bit 1 is also set.
- R4: A control write with exactly one selector bit arms a redirect for the next read. Bit 14 selects the threshold register, bit 13 the gain register and bit 11 the status word.
- R5: Exactly one read strobe consumes an armed redirect; later reads return sample_in. A control write with no selector bit leaves an armed redirect in place.
- R6: A control write with more than one of bits 14, 13 and 11 set arms no redirect and cancels any pending one. cfg_err is then high for exactly the one cycle after the data strobe. The non-one-shot bits of that write are still stored.
- R7: A control write with bit 9 set makes sync_pulse high for exactly the one cycle after the data strobe. Bits 14 to 11 and bit 9 are never stored, so they have no effect after that write.
- R8: The filter-settled flag is cleared by a synchronization write. It is set in a cycle where settle_in is high and no synchronization write occurs, and otherwise it holds.
- R9: The status word has these fields:
  - bit 15 is always 1;
  - bit 10 is the filter-settled flag;
  - bit 8 is the overrange flag;
  - bit 4 equals ref_buf_en;
  - bit 3 equals amp_en;
  - bit 2 equals low_power;
  - bits 1:0 equal dec_rate_in;
  - all other bits are 0.
- R10: The overrange flag is 1 when the magnitude of sample_in (two's complement) is strictly greater than the unsigned threshold register.
- R11: Writes to unknown addresses and to the status address change nothing.
- R12: rd_word takes the selected value on the clock edge where rd_stb is high, so it is visible the cycle after the strobe. It holds its value when rd_stb is low.
- R13: gain_o presents the gain register, and it is updated on the clock edge of a gain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_addr_stb | input | 1 | Address word strobe |
| wr_data_stb | input | 1 | Data word strobe |
| wr_word | input | 16 | Address or data word |
| rd_stb | input | 1 | Read strobe |
| rd_word | output | 16 | Read result |
| sample_in | input | 16 | Current conversion sample, two's complement |
| dec_rate_in | input | 2 | Decimation rate code in use |
| settle_in | input | 1 | Filter settled indication |
| gain_o | output | 16 | Digital gain register |
| sync_pulse | output | 1 | Single-cycle synchronization pulse |
| pwr_down | output | 1 | Power-down request |
| low_power | output | 1 | Low-power mode |
| ref_buf_en | output | 1 | Reference buffer enable |
| ref_bypass | output | 1 | Reference buffer bypass |
| amp_en | output | 1 | Input amplifier enable |
| cfg_err | output | 1 | Pulse for a control write with multiple read selectors |

## Verification
The assertions take for granted that every strobe is synchronous to clk. They also assume that a control write and a read strobe never fall in the same cycle, and that an address strobe and a data strobe never coincide. The stimulus keeps to this by issuing each address, data and read strobe in a separate cycle through tasks. It changes settle_in and sample_in only between transactions. The cycle model in the bench still follows the specified priority, in which a read consumes a redirect before a write arms a new one.

// File: rtl/cnv_regbank_pkg.sv
package cnv_regbank_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SRC_SAMPLE = 2'd0,
    SRC_THRESH = 2'd1,
    SRC_GAIN   = 2'd2,
    SRC_STATUS = 2'd3
  } rd_src_e;

  // control word bit positions
  localparam int CB_SEL_THR  = 14;
  localparam int CB_SEL_GAIN = 13;
  localparam int CB_SEL_STAT = 11;
  localparam int CB_SYNC     = 9;
  localparam int CB_BYPASS   = 7;
  localparam int CB_PDOWN    = 3;
  localparam int CB_LPWR     = 2;
  localparam int CB_REFOFF   = 1;
  localparam int CB_AMPOFF   = 0;

  // status word bit positions
  localparam int SB_ID      = 15;
  localparam int SB_SETTLED = 10;
  localparam int SB_OVR     = 8;
  localparam int SB_REFBUF  = 4;
  localparam int SB_AMP     = 3;
  localparam int SB_LPWR    = 2;

  // persistent control fields
  typedef struct packed {
    logic bypass;
    logic pdown;
    logic lpwr;
    logic refoff;
    logic ampoff;
  } ctrl_t;

endpackage

// File: rtl/cnv_wr_decode.sv
module cnv_wr_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 16'h0001,
  parameter logic [ADDR_W-1:0] ADDR_GAIN = 16'h0002,
  parameter logic [ADDR_W-1:0] ADDR_THR  = 16'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic              data_stb,
  input  logic [ADDR_W-1:0] word,
  output logic              ctrl_we,
  output logic              gain_we,
  output logic              thr_we
);

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fire;

  assign fire = data_stb & pend_q;

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    if (fire)     pend_d = 1'b0;
    if (addr_stb) begin
      pend_d = 1'b1;
      addr_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
    end
  end

  assign ctrl_we = fire & (addr_q == ADDR_CTRL);
  assign gain_we = fire & (addr_q == ADDR_GAIN);
  assign thr_we  = fire & (addr_q == ADDR_THR);

endmodule

// File: rtl/cnv_ctrl_regs.sv
module cnv_ctrl_regs
  import cnv_regbank_pkg::*;
#(
  parameter logic [WORD_W-1:0] GAIN_RST = 16'h4000,
  parameter logic [WORD_W-1:0] THR_RST  = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              gain_we,
  input  logic              thr_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_stb,
  input  logic              settle_in,
  output ctrl_t             ctrl_q,
  output logic [WORD_W-1:0] gain_q,
  output logic [WORD_W-1:0] thr_q,
  output rd_src_e           src_q,
  output logic              settled_q,
  output logic              sync_q,
  output logic              err_q
);

  ctrl_t             ctrl_d;
  logic [WORD_W-1:0] gain_d, thr_d;
  rd_src_e           src_d;
  logic              settled_d, sync_d, err_d;
  logic [2:0]        sel_vec;
  logic              multi_sel;

  assign sel_vec   = {wdata[CB_SEL_THR], wdata[CB_SEL_GAIN], wdata[CB_SEL_STAT]};
  assign multi_sel = ($countones(sel_vec) > 1);

  always_comb begin
    ctrl_d    = ctrl_q;
    gain_d    = gain_q;
    thr_d     = thr_q;
    src_d     = src_q;
    sync_d    = 1'b0;
    err_d     = 1'b0;
    if (rd_stb) src_d = SRC_SAMPLE;
    if (gain_we) gain_d = wdata;
    if (thr_we)  thr_d  = wdata;
    if (ctrl_we) begin
      ctrl_d.bypass = wdata[CB_BYPASS];
      ctrl_d.pdown  = wdata[CB_PDOWN];
      ctrl_d.lpwr   = wdata[CB_LPWR];
      ctrl_d.refoff = wdata[CB_REFOFF];
      ctrl_d.ampoff = wdata[CB_AMPOFF];
      sync_d        = wdata[CB_SYNC];
      if (multi_sel) begin
        err_d = 1'b1;
        src_d = SRC_SAMPLE;
      end else if (wdata[CB_SEL_THR]) begin
        src_d = SRC_THRESH;
      end else if (wdata[CB_SEL_GAIN]) begin
        src_d = SRC_GAIN;
      end else if (wdata[CB_SEL_STAT]) begin
        src_d = SRC_STATUS;
      end
    end
    if (sync_d)         settled_d = 1'b0;
    else if (settle_in) settled_d = 1'b1;
    else                settled_d = settled_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      gain_q    <= GAIN_RST;
      thr_q     <= THR_RST;
      src_q     <= SRC_SAMPLE;
      settled_q <= 1'b0;
      sync_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      gain_q    <= gain_d;
      thr_q     <= thr_d;
      src_q     <= src_d;
      settled_q <= settled_d;
      sync_q    <= sync_d;
      err_q     <= err_d;
    end
  end

endmodule

// File: rtl/cnv_rd_mux.sv
module cnv_rd_mux
  import cnv_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  rd_src_e           src,
  input  logic [WORD_W-1:0] sample,
  input  logic [WORD_W-1:0] gain,
  input  logic [WORD_W-1:0] thr,
  input  logic              settled,
  input  logic              refbuf_on,
  input  logic              amp_on,
  input  logic              lpwr,
  input  logic [1:0]        dec_rate,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W:0]   mag;
  logic              ovr;
  logic [WORD_W-1:0] status;
  logic [WORD_W-1:0] rd_d;

  // magnitude of the two's complement sample, one bit wider
  assign mag = sample[WORD_W-1] ? (~{1'b1, sample} + 1'b1) : {1'b0, sample};
  assign ovr = (mag > {1'b0, thr});

  always_comb begin
    status             = '0;
    status[SB_ID]      = 1'b1;
    status[SB_SETTLED] = settled;
    status[SB_OVR]     = ovr;
    status[SB_REFBUF]  = refbuf_on;
    status[SB_AMP]     = amp_on;
    status[SB_LPWR]    = lpwr;
    status[1:0]        = dec_rate;
  end

  always_comb begin
    rd_d = rd_word;
    if (rd_stb) begin
      unique case (src)
        SRC_THRESH: rd_d = thr;
        SRC_GAIN:   rd_d = gain;
        SRC_STATUS: rd_d = status;
        default:    rd_d = sample;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= '0;
    else        rd_word <= rd_d;
  end

endmodule

// File: rtl/cnv_regbank.sv
module cnv_regbank
  import cnv_regbank_pkg::*;
#(
  parameter logic [WORD_W-1:0] GAIN_RST = 16'h4000,
  parameter logic [WORD_W-1:0] THR_RST  = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr_stb,
  input  logic              wr_data_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_word,
  input  logic [WORD_W-1:0] sample_in,
  input  logic [1:0]        dec_rate_in,
  input  logic              settle_in,
  output logic [WORD_W-1:0] gain_o,
  output logic              sync_pulse,
  output logic              pwr_down,
  output logic              low_power,
  output logic              ref_buf_en,
  output logic              ref_bypass,
  output logic              amp_en,
  output logic              cfg_err
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              ctrl_we, gain_we, thr_we;
  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] thr_q;
  rd_src_e           src_q;
  logic              settled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cnv_wr_decode #(.ADDR_W(WORD_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_stb (wr_addr_stb),
    .data_stb (wr_data_stb),
    .word     (wr_word),
    .ctrl_we  (ctrl_we),
    .gain_we  (gain_we),
    .thr_we   (thr_we)
  );

  cnv_ctrl_regs #(.GAIN_RST(GAIN_RST), .THR_RST(THR_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctrl_we   (ctrl_we),
    .gain_we   (gain_we),
    .thr_we    (thr_we),
    .wdata     (wr_word),
    .rd_stb    (rd_stb),
    .settle_in (settle_in),
    .ctrl_q    (ctrl_q),
    .gain_q    (gain_o),
    .thr_q     (thr_q),
    .src_q     (src_q),
    .settled_q (settled_q),
    .sync_q    (sync_pulse),
    .err_q     (cfg_err)
  );

  assign pwr_down   = ctrl_q.pdown;
  assign low_power  = ctrl_q.lpwr;
  assign ref_buf_en = ~ctrl_q.refoff & ~ctrl_q.pdown;
  assign amp_en     = ~ctrl_q.ampoff & ~ctrl_q.pdown;
  assign ref_bypass = ctrl_q.bypass & ctrl_q.refoff;

  cnv_rd_mux u_rd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_stb    (rd_stb),
    .src       (src_q),
    .sample    (sample_in),
    .gain      (gain_o),
    .thr       (thr_q),
    .settled   (settled_q),
    .refbuf_on (ref_buf_en),
    .amp_on    (amp_en),
    .lpwr      (low_power),
    .dec_rate  (dec_rate_in),
    .rd_word   (rd_word)
  );

endmodule

// File: rtl/cnv_regbank_chk.sv
module cnv_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_data_stb,
  input logic        rd_stb,
  input logic [15:0] rd_word,
  input logic        sync_pulse,
  input logic        cfg_err,
  input logic        pwr_down,
  input logic        ref_buf_en,
  input logic        amp_en,
  input logic        ref_bypass
);

  // R7
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  // R7
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(wr_data_stb));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(wr_data_stb));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_word));

  // R3
  pdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!ref_buf_en && !amp_en));

  // R3
  bypass_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_bypass |-> !ref_buf_en);

endmodule

bind cnv_regbank cnv_regbank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_data_stb (wr_data_stb),
  .rd_stb      (rd_stb),
  .rd_word     (rd_word),
  .sync_pulse  (sync_pulse),
  .cfg_err     (cfg_err),
  .pwr_down    (pwr_down),
  .ref_buf_en  (ref_buf_en),
  .amp_en      (amp_en),
  .ref_bypass  (ref_bypass)
);

// File: tb/cnv_regbank_bench.sv
`timescale 1ns/1ps
module cnv_regbank_bench;

  localparam logic [15:0] GAIN_RST = 16'h4000;
  localparam logic [15:0] THR_RST  = 16'h7FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_addr_stb = 1'b0, wr_data_stb = 1'b0, rd_stb = 1'b0;
  logic [15:0] wr_word = '0, sample_in = '0;
  logic [1:0]  dec_rate_in = 2'b00;
  logic        settle_in = 1'b0;
  logic [15:0] rd_word, gain_o;
  logic        sync_pulse, pwr_down, low_power, ref_buf_en, ref_bypass, amp_en, cfg_err;

  int tests = 0, fails = 0;
  int sync_count = 0;
  logic last_err;

  cnv_regbank #(.GAIN_RST(GAIN_RST), .THR_RST(THR_RST)) u_cnv_regbank (.*);

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctrl = '0, m_gain = GAIN_RST, m_thr = THR_RST, m_addr = '0, m_rd = '0, m_st;
  bit  m_pend = 0, m_sync = 0, m_err = 0, m_settled = 0, m_started = 0, m_syncnow;
  int  m_src = 0, m_rel = 0, m_s, m_mag, m_nsel;
  bit  m_rbe, m_ae;

  always @(posedge clk) begin
    m_started = 1;
    if (!rst_n || m_rel < 2) begin
      if (rst_n) m_rel++; else m_rel = 0;
      m_ctrl = '0; m_gain = GAIN_RST; m_thr = THR_RST; m_addr = '0; m_rd = '0;
      m_pend = 0; m_sync = 0; m_err = 0; m_settled = 0; m_src = 0;
    end else begin
      m_rbe = !m_ctrl[1] && !m_ctrl[3];
      m_ae  = !m_ctrl[0] && !m_ctrl[3];
      m_s   = sample_in[15] ? int'(sample_in) - 65536 : int'(sample_in);
      m_mag = (m_s < 0) ? -m_s : m_s;
      m_st  = 16'h8000 | (m_settled ? 16'h0400 : 16'h0) | ((m_mag > int'(m_thr)) ? 16'h0100 : 16'h0)
            | (m_rbe ? 16'h0010 : 16'h0) | (m_ae ? 16'h0008 : 16'h0) | (m_ctrl[2] ? 16'h0004 : 16'h0)
            | {14'd0, dec_rate_in};
      m_sync = 0; m_err = 0; m_syncnow = 0;
      if (rd_stb) begin
        case (m_src)
          1: m_rd = m_thr;
          2: m_rd = m_gain;
          3: m_rd = m_st;
          default: m_rd = sample_in;
        endcase
        m_src = 0;
      end
      if (wr_data_stb && m_pend) begin
        m_pend = 0;
        if (m_addr == 16'h0001) begin
          m_nsel = int'(wr_word[14]) + int'(wr_word[13]) + int'(wr_word[11]);
          m_ctrl = wr_word & 16'h0085 | wr_word & 16'h0008 | wr_word & 16'h0002;
          if (m_nsel > 1) begin m_err = 1; m_src = 0; end
          else if (wr_word[14]) m_src = 1;
          else if (wr_word[13]) m_src = 2;
          else if (wr_word[11]) m_src = 3;
          m_sync = wr_word[9]; m_syncnow = wr_word[9];
        end else if (m_addr == 16'h0002) m_gain = wr_word;
        else if (m_addr == 16'h0003) m_thr = wr_word;
      end
      if (wr_addr_stb) begin m_pend = 1; m_addr = wr_word; end
      if (m_syncnow) m_settled = 0;
      else if (settle_in) m_settled = 1;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_started) begin
      check("R12 rd_word vs model", rd_word, m_rd);
      check("R13 gain_o vs model", gain_o, m_gain);
      check("R7 sync_pulse vs model", {15'd0, sync_pulse}, {15'd0, m_sync});
      check("R6 cfg_err vs model", {15'd0, cfg_err}, {15'd0, m_err});
      check("R3 pwr_down vs model", {15'd0, pwr_down}, {15'd0, m_ctrl[3]});
      check("R3 low_power vs model", {15'd0, low_power}, {15'd0, m_ctrl[2]});
      check("R3 ref_buf_en vs model", {15'd0, ref_buf_en}, {15'd0, !m_ctrl[1] && !m_ctrl[3]});
      check("R3 amp_en vs model", {15'd0, amp_en}, {15'd0, !m_ctrl[0] && !m_ctrl[3]});
      check("R3 ref_bypass vs model", {15'd0, ref_bypass}, {15'd0, m_ctrl[7] && m_ctrl[1]});
      if (sync_pulse) sync_count++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_addr_stb = 1'b1; wr_word = a;
    @(negedge clk); wr_addr_stb = 1'b0; wr_data_stb = 1'b1; wr_word = d;
    @(negedge clk); wr_data_stb = 1'b0; wr_word = '0;
    last_err = cfg_err;
  endtask

  task automatic data_only(input logic [15:0] d);
    @(negedge clk); wr_data_stb = 1'b1; wr_word = d;
    @(negedge clk); wr_data_stb = 1'b0; wr_word = '0;
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    v = rd_word;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rd_word reset", rd_word, 16'h0000);
    check("R1 gain reset", gain_o, GAIN_RST);
    check("R1 enables reset", {12'd0, pwr_down, low_power, ref_buf_en, amp_en}, 16'h0003);

    // R12 plain read returns sample
    sample_in = 16'h1234;
    do_read(v); check("R12 sample read", v, 16'h1234);

    // R13 / R4 / R5 gain redirect
    do_write(16'h0002, 16'h2A5A);
    check("R13 gain written", gain_o, 16'h2A5A);
    do_write(16'h0001, 16'h2000);
    do_read(v); check("R4 gain redirect", v, 16'h2A5A);
    do_read(v); check("R5 back to sample", v, 16'h1234);

    // R4 threshold redirect
    do_write(16'h0003, 16'h0100);
    do_write(16'h0001, 16'h4000);
    do_read(v); check("R4 threshold redirect", v, 16'h0100);

    // R5 pending redirect survives a selector-free control write
    do_write(16'h0001, 16'h2000);
    do_write(16'h0001, 16'h0000);
    do_read(v); check("R5 redirect kept", v, 16'h2A5A);

    // R9 / R10 status layout and overrange
    sample_in = 16'h0200; dec_rate_in = 2'b10;
    do_write(16'h0001, 16'h0804);
    do_read(v); check("R9 status layout ovr", v, 16'h811E);
    sample_in = 16'hFF00;
    do_write(16'h0001, 16'h0804);
    do_read(v); check("R10 magnitude equal threshold", v, 16'h801E);
    sample_in = 16'hFEFF;
    do_write(16'h0001, 16'h0804);
    do_read(v); check("R10 magnitude above threshold", v, 16'h811E);

    // R8 settled flag and sync
    @(negedge clk); settle_in = 1'b1;
    @(negedge clk); settle_in = 1'b0;
    do_write(16'h0001, 16'h0800);
    do_read(v); check("R8 settled set", v, 16'h851A);
    sync_count = 0;
    do_write(16'h0001, 16'h0200);
    repeat (3) @(negedge clk);
    check("R7 one sync pulse", 16'(sync_count), 16'd1);
    do_write(16'h0001, 16'h0800);
    do_read(v); check("R8 settled cleared by sync", v, 16'h811A);

    // R6 multiple selectors
    sample_in = 16'h0ABC;
    do_write(16'h0001, 16'h6000);
    check("R6 error pulse", {15'd0, last_err}, 16'd1);
    do_read(v); check("R6 no redirect armed", v, 16'h0ABC);
    do_write(16'h0001, 16'h2000);
    do_write(16'h0001, 16'h4804);
    do_read(v); check("R6 pending cancelled", v, 16'h0ABC);
    check("R6 plain bits still stored", {15'd0, low_power}, 16'd1);

    // R11 unknown and status addresses
    do_write(16'h0001, 16'h0000);
    do_write(16'h0005, 16'h0008);
    check("R11 unknown addr ignored", {15'd0, pwr_down}, 16'd0);
    do_write(16'h0004, 16'hFFFF);
    check("R11 status addr ignored", {15'd0, pwr_down}, 16'd0);
    check("R11 gain untouched", gain_o, 16'h2A5A);

    // R2 data without address
    data_only(16'h0008);
    check("R2 lone data ignored", {15'd0, pwr_down}, 16'd0);

    // R3 control outputs
    do_write(16'h0001, 16'h0008);
    check("R3 power down", {13'd0, pwr_down, ref_buf_en, amp_en}, 16'h0004);
    check("R3 gain kept in power down", gain_o, 16'h2A5A);
    do_write(16'h0001, 16'h0000);
    check("R3 power up", {13'd0, pwr_down, ref_buf_en, amp_en}, 16'h0003);
    do_write(16'h0001, 16'h0082);
    check("R3 bypass with buffer off", {14'd0, ref_bypass, ref_buf_en}, 16'h0002);
    do_write(16'h0001, 16'h0080);
    check("R3 bypass needs buffer off", {14'd0, ref_bypass, ref_buf_en}, 16'h0001);
    do_write(16'h0001, 16'h0001);
    check("R3 amp off", {14'd0, amp_en, ref_buf_en}, 16'h0001);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule